// File: doc/BRIEF.md
# System Control Register File with Per-Register Write Masking

This block holds the system-control registers of a 32-bit processor core: the translation staging registers, the processor status and cause pair, configuration, the load-linked address, the watch-high register and the debug control word. Software writes a register through a single write port, addressed by a 5-bit register number and a 3-bit select. Each write passes through that register's own mask. Bits outside the mask either keep their previous value or read as zero. A combinational read port returns each register's composed view. For some registers, that view differs from what is stored.

Beside the register contents, the block drives four processor mode flags: user mode, exception level, error level and debug mode. It also emits three one-cycle events and one held state. The events are: the address-space identifier changed, a pending interrupt was unmasked by setting the interrupt enable, and software requested an interrupt through the cause register. The held state is the hard-interrupt request, which is set by an unmask event and cleared when the interrupt enable falls. Every write takes effect on the clock edge that samples it. Every event is high for exactly the following cycle.

Top module: `sysctl_regfile`

## Requirements
- R1: A write or read with a non-zero select is honoured only for register numbers 16 and 28. Any other non-zero select write changes nothing, and such a read returns 0. Register 16 select 1 reads the constant parameter CFG1_VALUE (default 0x1E190C8A), and writes to it are ignored.
- R2: Index (register 0) retains its bit 31 on a write, takes bits 3:0 from the data, and holds every other bit at 0.
- R3: EntryLo0 (register 2) and EntryLo1 (register 3) store data bits 29:0. Bits 31:30 read as 0.
- R4: Context (register 4) retains bits 31:24 and takes bits 23:4. PageMask (register 5) keeps only bits 24:13. Wired (register 6) keeps only bits 3:0.
- R5: EntryHi (register 10) stores the data AND 0xFFFFF0FF. When the new bits 7:0 differ from the old ones, asid_chg is high for the one cycle after the write edge; otherwise it stays low.
- R6: Status (register 12) stores the data AND 0xFA78FF01. The same write loads mode_user, mode_erl and mode_exl from data bits 4, 2 and 1. A read returns the stored value with those flags ORed back into bits 4, 2 and 1.
- R7: A Status write that takes bit 0 (IE) from 0 to 1 pulses irq_raise for one cycle and sets irq_pending when all of the following hold: the new EXL and ERL are 0, mode_dbg is 0, and new Status[15:8] AND Cause[15:8] is non-zero. A Status write taking IE from 1 to 0 clears irq_pending.
- R8: A Cause (register 13) write changes only bits 9:8. Bits under 0xB000F87C are kept, and all other bits read 0. A 0-to-1 change on bit 8 or bit 9 pulses sw_irq_req for one cycle.
- R9: LLAddr (register 17) stores all 32 data bits and reads back the stored value shifted right by 4.
- R10: Debug (register 23) keeps the old bits under 0x8C03FC1F and takes the data bits under 0x13300120. Data bit 30 loads mode_dbg on every Debug write.
- R11: With HAS_TLB=0, Config0 (register 16 select 0) keeps the old bits under 0xFE17FF80 and takes data bit 0. With HAS_TLB=1, it keeps the bits under 0x8017FF80 and takes the bits under 0x7E000001. WatchHi (register 19) stores the data AND 0x40FF0FF8.
- R12: After reset, every register reads 0 except Status, which reads 0x00000004. mode_erl is 1, the other mode flags are 0, and all events and irq_pending are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | 5 | Write register number |
| wr_sel | input | 3 | Write select |
| wr_data | input | 32 | Write data |
| rd_reg | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Composed read value |
| mode_user | output | 1 | User-mode flag |
| mode_exl | output | 1 | Exception-level flag |
| mode_erl | output | 1 | Error-level flag |
| mode_dbg | output | 1 | Debug-mode flag |
| asid_chg | output | 1 | One-cycle event: address-space identifier changed |
| irq_raise | output | 1 | One-cycle event: pending interrupt unmasked |
| sw_irq_req | output | 1 | One-cycle event: software interrupt requested |
| irq_pending | output | 1 | Held hard-interrupt request |

## Verification
A single Status write can do two things in the same cycle. It can set the interrupt enable, and it can also change the exception-level and error-level flags that decide whether that rising enable may raise an interrupt. The raise decision must use the flags carried by the same write, not the old ones. The bench covers this in two steps. First, it writes Status with IE and EXL both set while a software interrupt is pending and unmasked, and expects no irq_raise. Then it clears IE and writes IE=1 with EXL=0, and expects irq_raise and irq_pending together in the cycle after that write. A pending interrupt that meets an active debug flag set by an earlier Debug write is judged the same way.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int DW = 32;

  // Write targets; SL_NONE means the access selects nothing writable.
  typedef enum logic [3:0] {
    SL_INDEX, SL_ELO0, SL_ELO1, SL_CTX, SL_PMASK, SL_WIRED, SL_EHI,
    SL_STATUS, SL_CAUSE, SL_CFG0, SL_LLADDR, SL_WATCHHI, SL_DEBUG, SL_NONE
  } slot_e;

  localparam int NSLOT = 13;

  localparam logic [4:0] RN_INDEX   = 5'd0;
  localparam logic [4:0] RN_ELO0    = 5'd2;
  localparam logic [4:0] RN_ELO1    = 5'd3;
  localparam logic [4:0] RN_CTX     = 5'd4;
  localparam logic [4:0] RN_PMASK   = 5'd5;
  localparam logic [4:0] RN_WIRED   = 5'd6;
  localparam logic [4:0] RN_EHI     = 5'd10;
  localparam logic [4:0] RN_STATUS  = 5'd12;
  localparam logic [4:0] RN_CAUSE   = 5'd13;
  localparam logic [4:0] RN_CFG     = 5'd16;
  localparam logic [4:0] RN_LLADDR  = 5'd17;
  localparam logic [4:0] RN_WATCHHI = 5'd19;
  localparam logic [4:0] RN_DEBUG   = 5'd23;
  localparam logic [4:0] RN_TAGS    = 5'd28;

  // Masks: KEEP = bits held from the old value, TAKE = bits from the data.
  localparam logic [DW-1:0] IDX_KEEP   = 32'h8000_0000;
  localparam logic [DW-1:0] IDX_TAKE   = 32'h0000_000F;
  localparam logic [DW-1:0] ELO_TAKE   = 32'h3FFF_FFFF;
  localparam logic [DW-1:0] CTX_KEEP   = 32'hFF00_0000;
  localparam logic [DW-1:0] CTX_TAKE   = 32'h00FF_FFF0;
  localparam logic [DW-1:0] PMASK_TAKE = 32'h01FF_E000;
  localparam logic [DW-1:0] WIRED_TAKE = 32'h0000_000F;
  localparam logic [DW-1:0] EHI_TAKE   = 32'hFFFF_F0FF;
  localparam logic [DW-1:0] ST_TAKE    = 32'hFA78_FF01;
  localparam logic [DW-1:0] CA_KEEP    = 32'hB000_F87C;
  localparam logic [DW-1:0] CA_TAKE    = 32'h0000_0300;
  localparam logic [DW-1:0] DBG_KEEP   = 32'h8C03_FC1F;
  localparam logic [DW-1:0] DBG_TAKE   = 32'h1330_0120;
  localparam logic [DW-1:0] WHI_TAKE   = 32'h40FF_0FF8;
  localparam logic [DW-1:0] CF0_KEEP_T = 32'h8017_FF80;
  localparam logic [DW-1:0] CF0_TAKE_T = 32'h7E00_0001;
  localparam logic [DW-1:0] CF0_KEEP_N = 32'hFE17_FF80;
  localparam logic [DW-1:0] CF0_TAKE_N = 32'h0000_0001;

  // Status bit positions the control logic decodes.
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_UM  = 4;
  localparam int DBG_DM = 30;

  typedef struct packed {
    logic user;
    logic exl;
    logic erl;
    logic dbg;
  } mode_t;

  function automatic logic [DW-1:0] merge_bits(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [DW-1:0] keep,
                                               input logic [DW-1:0] take);
    return (old_v & keep) | (new_v & take);
  endfunction

  function automatic logic sel_legal(input logic [4:0] rn, input logic [2:0] sel);
    return (sel == 3'd0) || (rn == RN_CFG) || (rn == RN_TAGS);
  endfunction

  function automatic slot_e slot_of(input logic [4:0] rn, input logic [2:0] sel);
    slot_e s;
    s = SL_NONE;
    if (sel == 3'd0) begin
      case (rn)
        RN_INDEX:   s = SL_INDEX;
        RN_ELO0:    s = SL_ELO0;
        RN_ELO1:    s = SL_ELO1;
        RN_CTX:     s = SL_CTX;
        RN_PMASK:   s = SL_PMASK;
        RN_WIRED:   s = SL_WIRED;
        RN_EHI:     s = SL_EHI;
        RN_STATUS:  s = SL_STATUS;
        RN_CAUSE:   s = SL_CAUSE;
        RN_CFG:     s = SL_CFG0;
        RN_LLADDR:  s = SL_LLADDR;
        RN_WATCHHI: s = SL_WATCHHI;
        RN_DEBUG:   s = SL_DEBUG;
        default:    s = SL_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/sc_wr_decode.sv
module sc_wr_decode
  import sc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [4:0]       wr_reg,
  input  logic [2:0]       wr_sel,
  output logic [NSLOT-1:0] we
);

  slot_e hit;
  logic  sel_ok;

  assign sel_ok = sel_legal(wr_reg, wr_sel);
  assign hit    = slot_of(wr_reg, wr_sel);

  for (genvar g = 0; g < NSLOT; g++) begin : g_we
    assign we[g] = wr_en && sel_ok && (hit == slot_e'(g));
  end

  // R1: illegal select never reaches a register
  a_r1_sel_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_ok) |-> (we == '0));
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

endmodule

// File: rtl/sc_mmu_regs.sv
module sc_mmu_regs
  import sc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_index,
  input  logic          we_elo0,
  input  logic          we_elo1,
  input  logic          we_ctx,
  input  logic          we_pmask,
  input  logic          we_wired,
  input  logic          we_ehi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] index_q,
  output logic [DW-1:0] elo0_q,
  output logic [DW-1:0] elo1_q,
  output logic [DW-1:0] ctx_q,
  output logic [DW-1:0] pmask_q,
  output logic [DW-1:0] wired_q,
  output logic [DW-1:0] ehi_q,
  output logic          asid_chg
);

  logic [DW-1:0] ehi_next;
  logic          asid_diff;

  assign ehi_next  = wdata & EHI_TAKE;
  assign asid_diff = we_ehi && (ehi_next[7:0] != ehi_q[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q  <= '0;
      elo0_q   <= '0;
      elo1_q   <= '0;
      ctx_q    <= '0;
      pmask_q  <= '0;
      wired_q  <= '0;
      ehi_q    <= '0;
      asid_chg <= 1'b0;
    end else begin
      if (we_index) index_q <= merge_bits(index_q, wdata, IDX_KEEP, IDX_TAKE);
      if (we_elo0)  elo0_q  <= wdata & ELO_TAKE;
      if (we_elo1)  elo1_q  <= wdata & ELO_TAKE;
      if (we_ctx)   ctx_q   <= merge_bits(ctx_q, wdata, CTX_KEEP, CTX_TAKE);
      if (we_pmask) pmask_q <= wdata & PMASK_TAKE;
      if (we_wired) wired_q <= wdata & WIRED_TAKE;
      if (we_ehi)   ehi_q   <= ehi_next;
      asid_chg <= asid_diff;
    end
  end

  // R2: probe-fail bit is never touched by a software write
  a_r2_probe_kept: assert property (@(posedge clk) disable iff (!rst_n)
    we_index |=> (index_q[31] == $past(index_q[31])));
  // R5: the event implies the identifier really moved
  a_r5_asid_moved: assert property (@(posedge clk) disable iff (!rst_n)
    asid_chg |-> $past(we_ehi));
  a_r5_asid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ehi && (wdata[7:0] == ehi_q[7:0])) |=> !asid_chg);

endmodule

// File: rtl/sc_ctrl_regs.sv
module sc_ctrl_regs
  import sc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_status,
  input  logic          we_cause,
  input  logic          we_debug,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] cause_q,
  output logic [DW-1:0] debug_q,
  output mode_t         mode,
  output logic          irq_raise,
  output logic          irq_pending,
  output logic          sw_irq_req
);

  logic [DW-1:0] status_next, cause_next, debug_next;
  logic          ie_rise, ie_fall, masked_hit, raise_now, sw_now;

  assign status_next = wdata & ST_TAKE;
  assign cause_next  = merge_bits(cause_q, wdata, CA_KEEP, CA_TAKE);
  assign debug_next  = merge_bits(debug_q, wdata, DBG_KEEP, DBG_TAKE);

  assign ie_rise    = we_status && wdata[ST_IE] && !status_q[ST_IE];
  assign ie_fall    = we_status && !wdata[ST_IE] && status_q[ST_IE];
  assign masked_hit = |(status_next[15:8] & cause_q[15:8]);
  // Mode gating uses the flags carried by this same write.
  assign raise_now  = ie_rise && !wdata[ST_EXL] && !wdata[ST_ERL] && !mode.dbg && masked_hit;
  assign sw_now     = we_cause && |(cause_next[9:8] & ~cause_q[9:8]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q    <= '0;
      cause_q     <= '0;
      debug_q     <= '0;
      mode        <= '{user: 1'b0, exl: 1'b0, erl: 1'b1, dbg: 1'b0};
      irq_raise   <= 1'b0;
      irq_pending <= 1'b0;
      sw_irq_req  <= 1'b0;
    end else begin
      if (we_status) begin
        status_q  <= status_next;
        mode.user <= wdata[ST_UM];
        mode.exl  <= wdata[ST_EXL];
        mode.erl  <= wdata[ST_ERL];
      end
      if (we_cause) cause_q <= cause_next;
      if (we_debug) begin
        debug_q  <= debug_next;
        mode.dbg <= wdata[DBG_DM];
      end
      irq_raise  <= raise_now;
      sw_irq_req <= sw_now;
      if (raise_now)    irq_pending <= 1'b1;
      else if (ie_fall) irq_pending <= 1'b0;
    end
  end

  // R6: flags follow the written status bits
  a_r6_flags_follow: assert property (@(posedge clk) disable iff (!rst_n)
    we_status |=> (mode.user == $past(wdata[ST_UM])) && (mode.exl == $past(wdata[ST_EXL])));
  // R7: a raise only leaves an enabled, unprivileged-exception state
  a_r7_raise_state: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raise |-> (status_q[ST_IE] && !mode.exl && !mode.erl && !mode.dbg && irq_pending));
  a_r7_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ie_fall |=> !irq_pending);
  // R8: a software request leaves at least one software bit set
  a_r8_sw_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
    sw_irq_req |-> (cause_q[9:8] != 2'b00));
  // R10: debug flag tracks data bit 30
  a_r10_dbg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    we_debug |=> (mode.dbg == $past(wdata[DBG_DM])));

endmodule

// File: rtl/sc_misc_regs.sv
module sc_misc_regs
  import sc_pkg::*;
#(
  parameter bit HAS_TLB = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_cfg0,
  input  logic          we_lladdr,
  input  logic          we_watchhi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg0_q,
  output logic [DW-1:0] lladdr_q,
  output logic [DW-1:0] watchhi_q
);

  logic [DW-1:0] cfg0_next;

  if (HAS_TLB) begin : g_cfg_tlb
    assign cfg0_next = merge_bits(cfg0_q, wdata, CF0_KEEP_T, CF0_TAKE_T);
  end else begin : g_cfg_plain
    assign cfg0_next = merge_bits(cfg0_q, wdata, CF0_KEEP_N, CF0_TAKE_N);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg0_q    <= '0;
      lladdr_q  <= '0;
      watchhi_q <= '0;
    end else begin
      if (we_cfg0)    cfg0_q    <= cfg0_next;
      if (we_lladdr)  lladdr_q  <= wdata;
      if (we_watchhi) watchhi_q <= wdata & WHI_TAKE;
    end
  end

  // R11: watch-high never holds bits outside its field set
  a_r11_whi_fields: assert property (@(posedge clk) disable iff (!rst_n)
    we_watchhi |=> ((watchhi_q & ~WHI_TAKE) == '0));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sc_pkg::*;
#(
  parameter bit          HAS_TLB    = 1'b0,
  parameter logic [31:0] CFG1_VALUE = 32'h1E19_0C8A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_reg,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_reg,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        mode_user,
  output logic        mode_exl,
  output logic        mode_erl,
  output logic        mode_dbg,
  output logic        asid_chg,
  output logic        irq_raise,
  output logic        sw_irq_req,
  output logic        irq_pending
);

  logic [NSLOT-1:0] we;
  logic [DW-1:0] index_q, elo0_q, elo1_q, ctx_q, pmask_q, wired_q, ehi_q;
  logic [DW-1:0] status_q, cause_q, debug_q, cfg0_q, lladdr_q, watchhi_q;
  logic [DW-1:0] status_view;
  mode_t         mode;

  sc_wr_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_sel(wr_sel), .we(we)
  );

  sc_mmu_regs u_mmu (
    .clk(clk), .rst_n(rst_n),
    .we_index(we[SL_INDEX]), .we_elo0(we[SL_ELO0]), .we_elo1(we[SL_ELO1]),
    .we_ctx(we[SL_CTX]), .we_pmask(we[SL_PMASK]), .we_wired(we[SL_WIRED]),
    .we_ehi(we[SL_EHI]), .wdata(wr_data),
    .index_q(index_q), .elo0_q(elo0_q), .elo1_q(elo1_q), .ctx_q(ctx_q),
    .pmask_q(pmask_q), .wired_q(wired_q), .ehi_q(ehi_q), .asid_chg(asid_chg)
  );

  sc_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .we_status(we[SL_STATUS]), .we_cause(we[SL_CAUSE]), .we_debug(we[SL_DEBUG]),
    .wdata(wr_data), .status_q(status_q), .cause_q(cause_q), .debug_q(debug_q),
    .mode(mode), .irq_raise(irq_raise), .irq_pending(irq_pending), .sw_irq_req(sw_irq_req)
  );

  sc_misc_regs #(.HAS_TLB(HAS_TLB)) u_misc (
    .clk(clk), .rst_n(rst_n),
    .we_cfg0(we[SL_CFG0]), .we_lladdr(we[SL_LLADDR]), .we_watchhi(we[SL_WATCHHI]),
    .wdata(wr_data), .cfg0_q(cfg0_q), .lladdr_q(lladdr_q), .watchhi_q(watchhi_q)
  );

  assign mode_user = mode.user;
  assign mode_exl  = mode.exl;
  assign mode_erl  = mode.erl;
  assign mode_dbg  = mode.dbg;

  always_comb begin
    status_view = status_q;
    status_view[ST_UM]  = status_q[ST_UM]  | mode.user;
    status_view[ST_ERL] = status_q[ST_ERL] | mode.erl;
    status_view[ST_EXL] = status_q[ST_EXL] | mode.exl;
  end

  always_comb begin
    rd_data = '0;
    if (!sel_legal(rd_reg, rd_sel)) begin
      rd_data = '0;
    end else if (rd_reg == RN_CFG) begin
      if (rd_sel == 3'd0)      rd_data = cfg0_q;
      else if (rd_sel == 3'd1) rd_data = CFG1_VALUE;
    end else if (rd_sel == 3'd0) begin
      case (rd_reg)
        RN_INDEX:   rd_data = index_q;
        RN_ELO0:    rd_data = elo0_q;
        RN_ELO1:    rd_data = elo1_q;
        RN_CTX:     rd_data = ctx_q;
        RN_PMASK:   rd_data = pmask_q;
        RN_WIRED:   rd_data = wired_q;
        RN_EHI:     rd_data = ehi_q;
        RN_STATUS:  rd_data = status_view;
        RN_CAUSE:   rd_data = cause_q;
        RN_LLADDR:  rd_data = lladdr_q >> 4;
        RN_WATCHHI: rd_data = watchhi_q;
        RN_DEBUG:   rd_data = debug_q;
        default:    rd_data = '0;
      endcase
    end
  end

  // R12: reset leaves only the error level raised
  a_r12_reset_state: assert property (@(posedge clk)
    !rst_n |=> (mode_erl && !mode_exl && !mode_user && !mode_dbg && !irq_pending));

endmodule

// File: tb/test_sysctl_regfile.sv
module test_sysctl_regfile;

  localparam logic [31:0] CFG1 = 32'h1E19_0C8A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_reg = '0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_reg = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        mode_user, mode_exl, mode_erl, mode_dbg;
  logic        asid_chg, irq_raise, sw_irq_req, irq_pending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // what: 0 = rd_data, 1 = {user,exl,erl,dbg}, 2 = {asid,raise,sw,pending}
  typedef struct {
    string       req;
    int          what;
    logic [31:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  sysctl_regfile #(.HAS_TLB(1'b0), .CFG1_VALUE(CFG1)) i_sysctl_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_reg(rd_reg), .rd_sel(rd_sel), .rd_data(rd_data),
    .mode_user(mode_user), .mode_exl(mode_exl), .mode_erl(mode_erl), .mode_dbg(mode_dbg),
    .asid_chg(asid_chg), .irq_raise(irq_raise), .sw_irq_req(sw_irq_req),
    .irq_pending(irq_pending)
  );

  // Monitor: compare every queued expectation at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.what)
        0:       act = rd_data;
        1:       act = {28'd0, mode_user, mode_exl, mode_erl, mode_dbg};
        default: act = {28'd0, asid_chg, irq_raise, sw_irq_req, irq_pending};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: what=%0d actual=%08h expected=%08h", it.req, it.what, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [4:0] r, input logic [2:0] s, input logic [31:0] d);
    step();
    wr_en = 1'b1; wr_reg = r; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic exp_ev(input string req, input logic asid, input logic rais,
                        input logic sw, input logic pend);
    item_t it;
    it.req = req; it.what = 2; it.exp = {28'd0, asid, rais, sw, pend};
    sb.push_back(it);
  endtask

  task automatic exp_mode(input string req, input logic u, input logic x,
                          input logic e, input logic dm);
    item_t it;
    it.req = req; it.what = 1; it.exp = {28'd0, u, x, e, dm};
    sb.push_back(it);
  endtask

  task automatic exp_rd(input string req, input logic [4:0] r, input logic [2:0] s,
                        input logic [31:0] e);
    item_t it;
    rd_reg = r; rd_sel = s;
    it.req = req; it.what = 0; it.exp = e;
    sb.push_back(it);
    @(negedge clk);
    #1;
  endtask

  // Expected-value helpers restated from the requirements.
  function automatic logic [31:0] keep_low(input logic [31:0] d, input int n);
    return d & ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] fld(input logic [31:0] d, input int hi, input int lo);
    logic [31:0] m;
    m = ((32'd1 << (hi - lo + 1)) - 32'd1) << lo;
    return d & m;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R12: reset state
    exp_mode("R12", 1'b0, 1'b0, 1'b1, 1'b0);
    exp_ev("R12", 1'b0, 1'b0, 1'b0, 1'b0);
    exp_rd("R12", 5'd12, 3'd0, 32'h0000_0004);
    exp_rd("R12", 5'd0, 3'd0, 32'h0);
    exp_rd("R12", 5'd13, 3'd0, 32'h0);
    exp_rd("R12", 5'd10, 3'd0, 32'h0);

    // R1: illegal select is ignored; register 16 select 1 is a constant
    wr(5'd2, 3'd1, 32'hFFFF_FFFF);
    exp_rd("R1", 5'd2, 3'd0, 32'h0);
    wr(5'd12, 3'd3, 32'hFFFF_FFFF);
    exp_mode("R1", 1'b0, 1'b0, 1'b1, 1'b0);
    exp_rd("R1", 5'd12, 3'd0, 32'h0000_0004);
    exp_rd("R1", 5'd16, 3'd1, CFG1);
    wr(5'd16, 3'd1, 32'h0);
    exp_rd("R1", 5'd16, 3'd1, CFG1);
    exp_rd("R1", 5'd2, 3'd2, 32'h0);

    // R2: Index
    wr(5'd0, 3'd0, 32'hFFFF_FFFF);
    exp_rd("R2", 5'd0, 3'd0, keep_low(32'hFFFF_FFFF, 4));
    wr(5'd0, 3'd0, 32'h8000_00A6);
    exp_rd("R2", 5'd0, 3'd0, 32'h0000_0006);

    // R3: EntryLo pair
    wr(5'd2, 3'd0, 32'hFFFF_FFFF);
    exp_rd("R3", 5'd2, 3'd0, keep_low(32'hFFFF_FFFF, 30));
    wr(5'd3, 3'd0, 32'hC000_0005);
    exp_rd("R3", 5'd3, 3'd0, 32'h0000_0005);

    // R4: Context, PageMask, Wired
    wr(5'd4, 3'd0, 32'hFFFF_FFFF);
    exp_rd("R4", 5'd4, 3'd0, fld(32'hFFFF_FFFF, 23, 4));
    wr(5'd5, 3'd0, 32'hFFFF_FFFF);
    exp_rd("R4", 5'd5, 3'd0, fld(32'hFFFF_FFFF, 24, 13));
    wr(5'd6, 3'd0, 32'h1234_567B);
    exp_rd("R4", 5'd6, 3'd0, keep_low(32'h1234_567B, 4));

    // R5: EntryHi and identifier change event
    wr(5'd10, 3'd0, 32'h1234_5678);
    exp_ev("R5", 1'b1, 1'b0, 1'b0, 1'b0);
    exp_rd("R5", 5'd10, 3'd0, 32'h1234_5078);
    exp_ev("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    wr(5'd10, 3'd0, 32'hABCD_EF78);
    exp_ev("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    exp_rd("R5", 5'd10, 3'd0, 32'hABCD_E078);

    // R8: software interrupt bits (sets bit 8 and 9)
    wr(5'd13, 3'd0, 32'hFFFF_FFFF);
    exp_ev("R8", 1'b0, 1'b0, 1'b1, 1'b0);
    exp_rd("R8", 5'd13, 3'd0, 32'h0000_0300);
    exp_ev("R8", 1'b0, 1'b0, 1'b0, 1'b0);
    wr(5'd13, 3'd0, 32'h0000_0300);
    exp_ev("R8", 1'b0, 1'b0, 1'b0, 1'b0);

    // R6 + R7: all writable bits plus flags, IE rises with EXL set: no raise
    wr(5'd12, 3'd0, 32'hFFFF_FFFF);
    exp_ev("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    exp_mode("R6", 1'b1, 1'b1, 1'b1, 1'b0);
    exp_rd("R6", 5'd12, 3'd0, 32'hFA78_FF01 | 32'h16);
    wr(5'd12, 3'd0, 32'h0000_0000);
    exp_mode("R6", 1'b0, 1'b0, 1'b0, 1'b0);
    exp_rd("R6", 5'd12, 3'd0, 32'h0);

    // R7: IE rise with pending masked software bit 8 raises
    wr(5'd12, 3'd0, 32'h0000_0101);
    exp_ev("R7", 1'b0, 1'b1, 1'b0, 1'b1);
    exp_rd("R7", 5'd12, 3'd0, 32'h0000_0101);
    exp_ev("R7", 1'b0, 1'b0, 1'b0, 1'b1);
    wr(5'd12, 3'd0, 32'h0000_0100);
    exp_ev("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    // IE rise with no mask bit enabled: no raise
    wr(5'd12, 3'd0, 32'h0000_0001);
    exp_ev("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    wr(5'd12, 3'd0, 32'h0000_0000);
    // IE rise with ERL set in the same write: no raise
    wr(5'd12, 3'd0, 32'h0000_0205);
    exp_ev("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    exp_mode("R7", 1'b0, 1'b0, 1'b1, 1'b0);
    wr(5'd12, 3'd0, 32'h0000_0000);

    // R10: Debug masks and flag; active debug blocks a raise (R7)
    wr(5'd23, 3'd0, 32'hFFFF_FFFF);
    exp_mode("R10", 1'b0, 1'b0, 1'b0, 1'b1);
    exp_rd("R10", 5'd23, 3'd0, 32'h1330_0120);
    wr(5'd12, 3'd0, 32'h0000_0201);
    exp_ev("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    wr(5'd12, 3'd0, 32'h0000_0000);
    wr(5'd23, 3'd0, 32'h0000_0000);
    exp_mode("R10", 1'b0, 1'b0, 1'b0, 1'b0);
    exp_rd("R10", 5'd23, 3'd0, 32'h1330_0120 & 32'h8C03_FC1F);

    // R8: clearing then re-setting one software bit
    wr(5'd13, 3'd0, 32'h0000_0000);
    exp_ev("R8", 1'b0, 1'b0, 1'b0, 1'b0);
    exp_rd("R8", 5'd13, 3'd0, 32'h0);
    wr(5'd13, 3'd0, 32'hFFFF_FE00);
    exp_ev("R8", 1'b0, 1'b0, 1'b1, 1'b0);
    exp_rd("R8", 5'd13, 3'd0, 32'h0000_0200);

    // R9: load-linked address view
    wr(5'd17, 3'd0, 32'h1234_5678);
    exp_rd("R9", 5'd17, 3'd0, 32'h0123_4567);

    // R11: Config0 (plain variant) and WatchHi
    wr(5'd16, 3'd0, 32'hFFFF_FFFF);
    exp_rd("R11", 5'd16, 3'd0, 32'h0000_0001);
    wr(5'd19, 3'd0, 32'hFFFF_FFFF);
    exp_rd("R11", 5'd19, 3'd0, 32'h40FF_0FF8);

    step();
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule